// File: doc/BRIEF.md
# Instruction Decoder with Register Scoreboard

This block sits between instruction fetch and execute. It holds one 32-bit instruction word at a time and splits it into a mnemonic code and three operand slots. The two least significant bits give the instruction type, and the type sets the length of the opcode and the layout of the operand fields. Source register numbers are turned into register values through two combinational read ports into a 24-entry register view. Entries 0 to 15 of the view are the scalar registers and entries 16 to 23 are vector registers 0 to 7.

A scoreboard keeps a small saturating count of outstanding writes for each register. An instruction that reads a register with writes still pending is held and reported as blocked. An instruction whose destination count is already at its limit is held in the same way. The count for the destination goes up only in the cycle the instruction leaves the decoder. The writeback side lowers it by one for each release pulse.

The control is a two-state machine. ST_EMPTY means no instruction is held, and ST_HOLD means one is held. The transitions are LOAD (ST_EMPTY to ST_HOLD when a word is accepted), CHAIN (ST_HOLD to ST_HOLD when the held word issues and a new word is accepted in the same cycle), DRAIN (ST_HOLD to ST_EMPTY when the held word issues and nothing new arrives) and WAIT (ST_HOLD stays put because of a hazard or because downstream is not ready).

Top module: `instr_decoder`

## Requirements
- R1: While reset is asserted, and right after it, in_ready is 1, out_valid is 0, out_blocked is 0 and no register has an outstanding write.
- R2: Bits [1:0] give the type: 00 register form, 01 immediate form, 10 jump form. The value 11 decodes as NOP (code 0), sets all three slots to 0, reads no register, checks out nothing and does not raise out_err.
- R3: For the register form, opcode bits [6:2] with values 1, 2 and 3 give the codes ADD=1, SUB=2 and MUL=3. For the jump form, opcode bits [5:2] with values 1 to 9 give the codes 4 to 12 (JUMP, JUMP_REL, JUMP_LINK, BR_EQ, BR_GT, BR_UNDER, BR_OVER, PUSH, POP). Every other opcode, and every immediate-form word, gives NOP (0). The operand fields are still decoded for these.
- R4: Register form: source A is bits [11:7], source B is bits [16:12] and the destination is bits [21:17]. s1 is the value of A, s2 is the value of B, and s3 is the destination number, zero-extended.
- R5: Immediate form: the source is bits [10:6], the destination is bits [15:11] and the immediate is bits [31:16]. s1 is the value of the source, s2 is the destination number and s3 is the immediate, zero-extended.
- R6: Jump form: the source is bits [10:6] and the immediate is bits [31:11]. s1 is the value of the source, s2 is the zero-extended immediate, and s3 is 0. No destination is checked out.
- R7: A register number above 23 in a field the form uses sets out_err while the word is held. Such a source reads as 0 and never blocks. Such a destination is not checked out.
- R8: If a source register has a pending write, the held word shows out_blocked=1 and out_valid=0. The word stays held and in_ready is 0 until the hazard clears.
- R9: A destination is checked out exactly once, in the cycle with out_valid and out_ready both 1. Waiting for out_ready adds no checkouts.
- R10: Each register counts up to 3 outstanding writes. A held word whose destination count is 3 is blocked until a release lowers the count.
- R11: Each release pulse (rel_valid with rel_reg) removes one outstanding write. A release of a register with nothing pending is ignored. A checkout and a release of the same register in the same cycle cancel each other.
- R12: in_ready is 1 when nothing is held, or when the held word issues in this cycle. A word accepted at a clock edge is decoded in the next cycle, so back-to-back words issue one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction word is offered |
| in_word | input | 32 | Instruction word |
| in_ready | output | 1 | Decoder accepts the offered word this cycle |
| out_ready | input | 1 | Downstream accepts a decoded instruction |
| rd_a_idx | output | 5 | Register view index for source A |
| rd_a_data | input | 32 | Value at rd_a_idx |
| rd_b_idx | output | 5 | Register view index for source B |
| rd_b_data | input | 32 | Value at rd_b_idx |
| rel_valid | input | 1 | Release one pending write |
| rel_reg | input | 5 | Register whose pending write is released |
| out_valid | output | 1 | Decoded instruction is free of hazards and offered |
| out_blocked | output | 1 | Held instruction is stalled by the scoreboard |
| out_err | output | 1 | Held instruction names a register above 23 |
| out_mnem | output | 6 | Mnemonic code |
| out_s1 | output | 32 | Operand slot 1 |
| out_s2 | output | 32 | Operand slot 2 |
| out_s3 | output | 32 | Operand slot 3 |

## Verification
The bench targets a reader that directly follows its producer, a word held back by out_ready, a destination written three times with no release, a release of an idle register, and a checkout and release of the same register in one cycle. A decoder that counts checkouts while the word waits would keep later readers blocked after a single release. A counter that wraps on an ignored release would block a reader of an idle register, and a missing saturation check would let a fourth write through. Out-of-range register numbers, type 11, and opcodes just outside the assigned ranges are also driven, since a wrong field slice or range check would show up as a wrong code, slot value or error flag.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int MNEM_W = 6;

    typedef enum logic [MNEM_W-1:0] {
        MN_NOP       = 6'd0,
        MN_ADD       = 6'd1,
        MN_SUB       = 6'd2,
        MN_MUL       = 6'd3,
        MN_JUMP      = 6'd4,
        MN_JUMP_REL  = 6'd5,
        MN_JUMP_LINK = 6'd6,
        MN_BR_EQ     = 6'd7,
        MN_BR_GT     = 6'd8,
        MN_BR_UNDER  = 6'd9,
        MN_BR_OVER   = 6'd10,
        MN_PUSH      = 6'd11,
        MN_POP       = 6'd12
    } mnem_e;

    typedef enum logic [1:0] {
        TY_REG = 2'b00,
        TY_IMM = 2'b01,
        TY_JMP = 2'b10,
        TY_BAD = 2'b11
    } itype_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } dec_state_e;

endpackage

// File: rtl/dec_fields.sv
module dec_fields
    import dec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input  logic [XLEN-1:0]  word,
    input  logic [XLEN-1:0]  val_a,
    input  logic [XLEN-1:0]  val_b,
    output mnem_e            mnem,
    output logic [REG_W-1:0] idx_a,
    output logic [REG_W-1:0] idx_b,
    output logic [REG_W-1:0] idx_d,
    output logic             use_a,
    output logic             use_b,
    output logic             use_d,
    output logic [XLEN-1:0]  s1,
    output logic [XLEN-1:0]  s2,
    output logic [XLEN-1:0]  s3
);
    localparam int TY_W  = 2;
    localparam int ROP_W = 5;
    localparam int OP_W  = 4;
    localparam int RB    = TY_W + ROP_W;
    localparam int SB    = TY_W + OP_W;
    localparam int IMM_I = SB + 2 * REG_W;
    localparam int IMM_J = SB + REG_W;

    logic [ROP_W-1:0] rop;
    logic [OP_W-1:0]  op;
    logic [XLEN-1:0]  imm_i;
    logic [XLEN-1:0]  imm_j;

    assign rop   = word[RB-1:TY_W];
    assign op    = word[SB-1:TY_W];
    assign imm_i = word >> IMM_I;
    assign imm_j = word >> IMM_J;

    always_comb begin
        mnem  = MN_NOP;
        idx_a = '0;
        idx_b = '0;
        idx_d = '0;
        use_a = 1'b0;
        use_b = 1'b0;
        use_d = 1'b0;
        s1    = '0;
        s2    = '0;
        s3    = '0;
        unique case (itype_e'(word[TY_W-1:0]))
            TY_REG: begin
                idx_a = word[RB +: REG_W];
                idx_b = word[RB + REG_W +: REG_W];
                idx_d = word[RB + 2*REG_W +: REG_W];
                use_a = 1'b1;
                use_b = 1'b1;
                use_d = 1'b1;
                s1    = val_a;
                s2    = val_b;
                s3    = XLEN'(word[RB + 2*REG_W +: REG_W]);
                if (rop >= ROP_W'(1) && rop <= ROP_W'(3))
                    mnem = mnem_e'(MNEM_W'(rop));
            end
            TY_IMM: begin
                idx_a = word[SB +: REG_W];
                idx_d = word[SB + REG_W +: REG_W];
                use_a = 1'b1;
                use_d = 1'b1;
                s1    = val_a;
                s2    = XLEN'(word[SB + REG_W +: REG_W]);
                s3    = imm_i;
            end
            TY_JMP: begin
                idx_a = word[SB +: REG_W];
                use_a = 1'b1;
                s1    = val_a;
                s2    = imm_j;
                if (op >= OP_W'(1) && op <= OP_W'(9))
                    mnem = mnem_e'(MNEM_W'(op) + MNEM_W'(3));
            end
            TY_BAD: begin
                mnem = MN_NOP;
            end
        endcase
    end

endmodule

// File: rtl/dec_scoreboard.sv
module dec_scoreboard #(
    parameter int NUM_REGS = 24,
    parameter int REG_W    = 5,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [REG_W-1:0] chk_idx,
    input  logic             rel_en,
    input  logic [REG_W-1:0] rel_idx,
    input  logic [REG_W-1:0] q_a_idx,
    input  logic [REG_W-1:0] q_b_idx,
    input  logic [REG_W-1:0] q_d_idx,
    output logic             busy_a,
    output logic             busy_b,
    output logic             full_d
);
    localparam int SPAN = 1 << REG_W;

    logic [SPAN-1:0] busy_vec;
    logic [SPAN-1:0] full_vec;
    logic [SPAN-1:0] one_vec;

    for (genvar g = 0; g < SPAN; g++) begin : g_ent
        if (g < NUM_REGS) begin : g_live
            logic [CNT_W-1:0] cnt;
            logic inc;
            logic dec;
            assign inc = chk_en && (chk_idx == REG_W'(g));
            assign dec = rel_en && (rel_idx == REG_W'(g)) && ((cnt != '0) || inc);
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= '0;
                else        cnt <= cnt + CNT_W'(inc) - CNT_W'(dec);
            end
            assign busy_vec[g] = (cnt != '0);
            assign full_vec[g] = &cnt;
            assign one_vec[g]  = (cnt == CNT_W'(1));
        end else begin : g_pad
            assign busy_vec[g] = 1'b0;
            assign full_vec[g] = 1'b0;
            assign one_vec[g]  = 1'b0;
        end
    end

    assign busy_a = busy_vec[q_a_idx];
    assign busy_b = busy_vec[q_b_idx];
    assign full_d = full_vec[q_d_idx];

    // R9
    checkout_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !(rel_en && rel_idx == chk_idx)) |=> busy_vec[$past(chk_idx)]);

    // R11
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && one_vec[rel_idx] && !(chk_en && chk_idx == rel_idx))
        |=> !busy_vec[$past(rel_idx)]);

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> !full_vec[chk_idx]);

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import dec_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_W    = 5,
    parameter int NUM_REGS = 24,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [XLEN-1:0]  in_word,
    output logic             in_ready,
    input  logic             out_ready,
    output logic [REG_W-1:0] rd_a_idx,
    input  logic [XLEN-1:0]  rd_a_data,
    output logic [REG_W-1:0] rd_b_idx,
    input  logic [XLEN-1:0]  rd_b_data,
    input  logic             rel_valid,
    input  logic [REG_W-1:0] rel_reg,
    output logic             out_valid,
    output logic             out_blocked,
    output logic             out_err,
    output logic [MNEM_W-1:0] out_mnem,
    output logic [XLEN-1:0]  out_s1,
    output logic [XLEN-1:0]  out_s2,
    output logic [XLEN-1:0]  out_s3
);
    localparam logic [REG_W-1:0] LAST_IDX = REG_W'(NUM_REGS - 1);

    dec_state_e       state_q, state_d;
    logic [XLEN-1:0]  word_q;
    logic             held, hazard, issue, accept, bad;
    logic             a_ok, b_ok, d_ok;
    logic             busy_a, busy_b, full_d;
    mnem_e            mnem;
    logic [REG_W-1:0] idx_a, idx_b, idx_d;
    logic             use_a, use_b, use_d;
    logic [XLEN-1:0]  val_a, val_b;
    logic [XLEN-1:0]  s1, s2, s3;

    assign a_ok  = use_a && (idx_a <= LAST_IDX);
    assign b_ok  = use_b && (idx_b <= LAST_IDX);
    assign d_ok  = use_d && (idx_d <= LAST_IDX);
    assign val_a = a_ok ? rd_a_data : '0;
    assign val_b = b_ok ? rd_b_data : '0;

    dec_fields #(.XLEN(XLEN), .REG_W(REG_W)) u_fields (
        .word  (word_q),
        .val_a (val_a),
        .val_b (val_b),
        .mnem  (mnem),
        .idx_a (idx_a),
        .idx_b (idx_b),
        .idx_d (idx_d),
        .use_a (use_a),
        .use_b (use_b),
        .use_d (use_d),
        .s1    (s1),
        .s2    (s2),
        .s3    (s3)
    );

    dec_scoreboard #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (issue && d_ok),
        .chk_idx (idx_d),
        .rel_en  (rel_valid),
        .rel_idx (rel_reg),
        .q_a_idx (idx_a),
        .q_b_idx (idx_b),
        .q_d_idx (idx_d),
        .busy_a  (busy_a),
        .busy_b  (busy_b),
        .full_d  (full_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) word_q <= in_word;
        end
    end

    // outputs and transitions
    always_comb begin
        held   = (state_q == ST_HOLD);
        hazard = held && ((a_ok && busy_a) || (b_ok && busy_b) || (d_ok && full_d));
        bad    = (use_a && !a_ok) || (use_b && !b_ok) || (use_d && !d_ok);

        out_valid   = held && !hazard;
        out_blocked = hazard;
        out_err     = held && bad;
        issue       = out_valid && out_ready;
        in_ready    = !held || issue;
        accept      = in_valid && in_ready;

        rd_a_idx = a_ok ? idx_a : '0;
        rd_b_idx = b_ok ? idx_b : '0;
        out_mnem = mnem;
        out_s1   = s1;
        out_s2   = s2;
        out_s3   = s3;

        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_HOLD;   // LOAD
            ST_HOLD: begin
                if (issue && !in_valid) state_d = ST_EMPTY; // DRAIN
                else                    state_d = ST_HOLD;  // CHAIN or WAIT
            end
        endcase
    end

    // R8
    stall_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !issue) |=> (state_q == ST_HOLD && $stable(word_q)));

    // R12
    accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (state_q == ST_HOLD));

endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        out_ready = 1'b0;
    logic [4:0]  rd_a_idx, rd_b_idx;
    logic [31:0] rd_a_data, rd_b_data;
    logic        rel_valid = 1'b0;
    logic [4:0]  rel_reg = '0;
    logic        out_valid, out_blocked, out_err;
    logic [5:0]  out_mnem;
    logic [31:0] out_s1, out_s2, out_s3;

    logic [31:0] rf [24];
    int          cnt [24];
    bit          m_held = 1'b0;
    logic [31:0] m_word = '0;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign rd_a_data = (rd_a_idx < 5'd24) ? rf[rd_a_idx] : 32'hDEAD_BEEF;
    assign rd_b_data = (rd_b_idx < 5'd24) ? rf[rd_b_idx] : 32'hDEAD_BEEF;

    instr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .out_ready(out_ready),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rel_valid(rel_valid), .rel_reg(rel_reg),
        .out_valid(out_valid), .out_blocked(out_blocked), .out_err(out_err),
        .out_mnem(out_mnem), .out_s1(out_s1), .out_s2(out_s2), .out_s3(out_s3)
    );

    function automatic logic [31:0] enc_r(int op, int a, int b, int d);
        return {10'b0, 5'(d), 5'(b), 5'(a), 5'(op), 2'b00};
    endfunction
    function automatic logic [31:0] enc_i(int op, int a, int d, logic [15:0] imm);
        return {imm, 5'(d), 5'(a), 4'(op), 2'b01};
    endfunction
    function automatic logic [31:0] enc_j(int op, int a, logic [20:0] imm);
        return {imm, 5'(a), 4'(op), 2'b10};
    endfunction

    function automatic logic [31:0] rval(int r);
        return (r < 24) ? rf[r] : 32'd0;
    endfunction
    function automatic bit busy(int r);
        return (r < 24) && (cnt[r] > 0);
    endfunction
    function automatic bit fullc(int r);
        return (r < 24) && (cnt[r] == 3);
    endfunction

    task automatic predict(input logic [31:0] w, output int mn,
                           output logic [31:0] s1, output logic [31:0] s2,
                           output logic [31:0] s3, output bit blk, output bit err,
                           output bit dv, output int d);
        int a, b, op;
        mn = 0; s1 = 0; s2 = 0; s3 = 0; blk = 0; err = 0; dv = 0; d = 0;
        case (w[1:0])
            2'b00: begin
                a = int'(w[11:7]); b = int'(w[16:12]); d = int'(w[21:17]);
                op = int'(w[6:2]);
                mn = (op >= 1 && op <= 3) ? op : 0;
                s1 = rval(a); s2 = rval(b); s3 = 32'(d);
                blk = busy(a) || busy(b) || fullc(d);
                err = (a > 23) || (b > 23) || (d > 23);
                dv = (d < 24);
            end
            2'b01: begin
                a = int'(w[10:6]); d = int'(w[15:11]);
                s1 = rval(a); s2 = 32'(d); s3 = {16'b0, w[31:16]};
                blk = busy(a) || fullc(d);
                err = (a > 23) || (d > 23);
                dv = (d < 24);
            end
            2'b10: begin
                a = int'(w[10:6]); op = int'(w[5:2]);
                mn = (op >= 1 && op <= 9) ? op + 3 : 0;
                s1 = rval(a); s2 = {11'b0, w[31:11]}; s3 = 0;
                blk = busy(a);
                err = (a > 23);
            end
            default: ;
        endcase
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit iv, input logic [31:0] w, input bit ordy,
                        input bit rv, input int rr, input string tg);
        int mn, d, old;
        logic [31:0] s1, s2, s3;
        bit blk, err, dv, ok, iss, inr, inc, dec;
        string ft;
        @(negedge clk);
        in_valid = iv; in_word = w; out_ready = ordy;
        rel_valid = rv; rel_reg = 5'(rr);
        #1;
        predict(m_word, mn, s1, s2, s3, blk, err, dv, d);
        ok  = m_held && !blk;
        iss = ok && ordy;
        inr = !m_held || iss;
        chk(out_valid === ok, tg, "out_valid", 32'(out_valid), 32'(ok));
        chk(out_blocked === (m_held && blk), tg, "out_blocked",
            32'(out_blocked), 32'(m_held && blk));
        chk(in_ready === inr, "R12", "in_ready", 32'(in_ready), 32'(inr));
        if (m_held) begin
            case (m_word[1:0])
                2'b00: ft = "R4";
                2'b01: ft = "R5";
                2'b10: ft = "R6";
                default: ft = "R2";
            endcase
            chk(out_mnem === 6'(mn), "R3", "mnem", 32'(out_mnem), 32'(mn));
            chk(out_s1 === s1, ft, "s1", out_s1, s1);
            chk(out_s2 === s2, ft, "s2", out_s2, s2);
            chk(out_s3 === s3, ft, "s3", out_s3, s3);
            chk(out_err === err, "R7", "err", 32'(out_err), 32'(err));
        end
        @(posedge clk);
        if (rv && rr < 24) begin
            inc = iss && dv && (d == rr);
            old = cnt[rr];
            dec = (old > 0) || inc;
            if (dec) cnt[rr] = cnt[rr] - 1;
        end
        if (iss && dv) cnt[d] = cnt[d] + 1;
        if (iv && inr) begin
            m_held = 1'b1;
            m_word = w;
        end else if (iss) begin
            m_held = 1'b0;
        end
    endtask

    function automatic int rreg();
        return ($urandom % 10 == 0) ? 24 + int'($urandom % 8) : int'($urandom % 24);
    endfunction

    function automatic int pick_rel();
        for (int k = 0; k < 6; k++) begin
            int r = int'($urandom % 24);
            if (cnt[r] > 0) return r;
        end
        return int'($urandom % 26);
    endfunction

    function automatic logic [31:0] rand_word();
        int t = int'($urandom % 10);
        if (t < 4) return enc_r(int'($urandom % 6), rreg(), rreg(), rreg());
        if (t < 6) return enc_i(int'($urandom % 16), rreg(), rreg(), 16'($urandom));
        if (t < 9) return enc_j(int'($urandom % 12), rreg(), 21'($urandom));
        return $urandom | 32'h3;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 24; i++) begin
            rf[i] = $urandom;
            cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(in_ready === 1'b1, "R1", "in_ready in reset", 32'(in_ready), 32'd1);
        chk(out_valid === 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        chk(out_blocked === 1'b0, "R1", "out_blocked in reset", 32'(out_blocked), 32'd0);
        rst_n = 1'b1;

        // R1: nothing pending after reset, reader of every field issues at once
        step(1, enc_r(1, 1, 2, 3), 1, 0, 0, "R1");
        step(1, enc_r(2, 3, 20, 8), 1, 0, 0, "R1");
        // R8: reader of r3 right behind its producer
        for (int k = 0; k < 3; k++) step(0, 0, 1, 0, 0, "R8");
        step(0, 0, 1, 1, 3, "R8");
        step(0, 0, 1, 0, 0, "R8");
        step(0, 0, 1, 1, 8, "R8");

        // R9: producer waits on out_ready, checks out once
        step(1, enc_i(3, 0, 4, 16'h1234), 0, 0, 0, "R9");
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, "R9");
        step(1, enc_j(1, 4, 21'h0ABCD), 1, 0, 0, "R9");
        step(0, 0, 1, 1, 4, "R9");
        step(0, 0, 1, 0, 0, "R9");
        step(0, 0, 1, 0, 0, "R9");

        // R10: three writes to r5, fourth blocked until a release
        for (int k = 0; k < 4; k++) step(1, enc_i(1, 0, 5, 16'(k)), 1, 0, 0, "R10");
        step(0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 1, 5, "R10");
        step(0, 0, 1, 0, 0, "R10");
        for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 5, "R10");

        // R11: release of idle register ignored; same-cycle checkout and release
        step(0, 0, 1, 1, 6, "R11");
        step(1, enc_r(3, 6, 6, 7), 1, 0, 0, "R11");
        step(1, enc_j(2, 7, 21'h1), 1, 1, 7, "R11");
        step(0, 0, 1, 0, 0, "R11");

        // R2 and R7: invalid type, out-of-range registers
        step(1, 32'hFFFF_FFFF, 1, 0, 0, "R2");
        step(1, enc_r(1, 25, 2, 30), 1, 0, 0, "R7");
        step(1, enc_i(0, 31, 28, 16'hFFFF), 1, 0, 0, "R7");
        // R3: all jump opcodes and neighbours
        for (int op = 0; op < 16; op++) step(1, enc_j(op, 16 + op % 8, 21'(op)), 1, 0, 0, "R3");
        for (int op = 0; op < 8; op++) step(1, enc_r(op, 23, 0, 22), 1, 1, 22, "R3");
        step(0, 0, 1, 1, 22, "R3");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit iv = ($urandom % 4) != 0;
            bit od = ($urandom % 5) != 0;
            bit rv = ($urandom % 3) == 0;
            if (i % 97 == 0) rf[$urandom % 24] = $urandom;
            step(iv, rand_word(), od, rv, pick_rel(), "R8");
        end
        for (int i = 0; i < 60; i++) step(0, 0, 1, 1, pick_rel(), "R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule